// File: doc/BRIEF.md
# Audio Control Register Slave (I2C write-only)

This block is the control front end of a stereo volume and tone processor. A host writes settings over a two-wire I2C bus, and the block holds them in five registers. Their values go straight to the analog path as parallel codes: one volume code per channel, a bass code, a treble code and a surround enable. The block only accepts writes. It oversamples SCL and SDA with its system clock, finds start and stop conditions, and matches its device address. It acknowledges by pulling SDA low through an open-drain enable output.

Every transfer has the same shape. The address byte comes first. The byte after it selects a register. All bytes after that are data. Each data byte lands in the selected register, and the selection then steps to the next entry of a five-entry ring, so one transfer can refresh all settings from any starting point. A one-cycle strobe output shows which register was written, in the same cycle its output changes.

Top module: `audio_ctl_i2c_slave`

## Requirements
- R1: After reset, both volume outputs are 0x00, bass and treble are 0x1F, surround is off, sda_oe is low and no strobe bit is set.
- R2: The device answers the write-form address byte {6'b100000, addr_sel, 0}, which is 0x80 when addr_sel is low and 0x82 when it is high. It acknowledges by driving sda_oe high for the ninth clock.
- R3: An address byte that does not match, or that has bit 0 (read) set, gets no acknowledge. Every later byte is ignored until the next start, and no register changes.
- R4: The first byte after the address selects the register: 0 is channel 1 volume, 1 is channel 2 volume, 2 is bass, 3 is treble and 4 is surround. The next byte is written there, taken MSB first. Every byte is acknowledged.
- R5: Each further data byte goes to the next register in the ring 0,1,2,3,4,0 and so on.
- R6: After the selection byte, every byte in the same transfer is data, even when its value looks like a register number.
- R7: Bass and treble keep only bits 5..0 of their byte. Surround keeps only bit 0.
- R8: A selection byte of 5 or more is acknowledged. So are the data bytes after it, but they change no register and raise no strobe.
- R9: A start, including a repeated start in the middle of a transfer, begins address reception again. A stop ends the transfer.
- R10: wr_strobe has at most one bit set, for exactly one cycle per write. That bit is the written register's number, and the register's output changes only in a cycle where its strobe bit is set.
- R11: sda_oe goes high and goes low only while SCL is low. It is released after the falling SCL edge that ends the ninth clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_sel | input | 1 | Strap that sets the lowest device address bit |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_oe | output | 1 | High pulls SDA low (acknowledge) |
| vol_ch1 | output | 8 | Channel 1 volume code |
| vol_ch2 | output | 8 | Channel 2 volume code |
| bass | output | 6 | Bass code |
| treble | output | 6 | Treble code |
| surround_en | output | 1 | Surround enable |
| wr_strobe | output | 5 | One-hot pulse naming the register just written |

## Verification
In a single cycle, the register write can coincide with the step of the selection index past the top of the ring. Surround (register 4) is written, and the index returns to 0. The bench provokes this with a transfer that selects treble and then sends four data bytes, so the writes run through 3, 4, 0 and 1. It judges the result by the four final register values and by a strobe count of exactly four.

A repeated start can also arrive while a transfer is still selecting a register. This case is judged by the register that receives the data after the restart.

// File: rtl/aud_ctl_pkg.sv
package aud_ctl_pkg;

  localparam int NUM_CTL_REGS = 5;

  localparam logic [2:0] IDX_VOL1  = 3'd0;
  localparam logic [2:0] IDX_VOL2  = 3'd1;
  localparam logic [2:0] IDX_BASS  = 3'd2;
  localparam logic [2:0] IDX_TREB  = 3'd3;
  localparam logic [2:0] IDX_SURR  = 3'd4;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RECV,
    PH_ACK_ARM,
    PH_ACK,
    PH_SKIP
  } phase_t;

  typedef enum logic [1:0] {
    BK_ADDR,
    BK_INDEX,
    BK_DATA
  } byte_kind_t;

  // Write-form address test: upper six bits fixed, one bit from the strap, R/W low.
  function automatic logic addr_is_write_hit(input logic [7:0] b,
                                             input logic [5:0] hi,
                                             input logic strap);
    return (b[7:1] == {hi, strap}) && (b[0] == 1'b0);
  endfunction

endpackage

// File: rtl/i2c_line_sampler.sv
module i2c_line_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [SYNC_STAGES-1:0] scl_sync, sda_sync;
  logic scl_prev, sda_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync <= '1;
      sda_sync <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_i};
      sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_i};
      scl_prev <= scl_sync[SYNC_STAGES-1];
      sda_prev <= sda_sync[SYNC_STAGES-1];
    end
  end

  assign scl_lvl   = scl_sync[SYNC_STAGES-1];
  assign sda_lvl   = sda_sync[SYNC_STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_prev;
  assign scl_fall  = ~scl_lvl & scl_prev;
  assign start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;

endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
  import aud_ctl_pkg::*;
#(
  parameter logic [5:0] DEV_ADDR_HI = 6'b100000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       addr_sel,
  input  logic       scl_lvl,
  input  logic       sda_lvl,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  output logic       sda_oe,
  output logic       idx_load,
  output logic       data_load,
  output logic [7:0] rx_byte
);

  phase_t     phase;
  byte_kind_t kind;
  logic [2:0] bit_cnt;
  logic [7:0] shreg;
  logic       byte_full;
  logic       addr_hit;

  assign rx_byte   = {shreg[6:0], sda_lvl};
  assign byte_full = (phase == PH_RECV) && scl_rise && (bit_cnt == 3'd7);
  assign addr_hit  = byte_full && (kind == BK_ADDR) &&
                     addr_is_write_hit(rx_byte, DEV_ADDR_HI, addr_sel);
  assign idx_load  = byte_full && (kind == BK_INDEX);
  assign data_load = byte_full && (kind == BK_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      kind    <= BK_ADDR;
      bit_cnt <= '0;
      shreg   <= '0;
      sda_oe  <= 1'b0;
    end else if (start_det) begin
      phase   <= PH_RECV;
      kind    <= BK_ADDR;
      bit_cnt <= '0;
      sda_oe  <= 1'b0;
    end else if (stop_det) begin
      phase  <= PH_IDLE;
      sda_oe <= 1'b0;
    end else begin
      unique case (phase)
        PH_RECV: begin
          if (scl_rise) begin
            shreg <= rx_byte;
            if (bit_cnt == 3'd7) begin
              bit_cnt <= '0;
              if (kind == BK_ADDR && !addr_hit) phase <= PH_SKIP;
              else                              phase <= PH_ACK_ARM;
            end else begin
              bit_cnt <= bit_cnt + 3'd1;
            end
          end
        end
        PH_ACK_ARM: begin
          if (scl_fall) begin
            sda_oe <= 1'b1;
            phase  <= PH_ACK;
          end
        end
        PH_ACK: begin
          if (scl_fall) begin
            sda_oe <= 1'b0;
            phase  <= PH_RECV;
            kind   <= (kind == BK_ADDR) ? BK_INDEX : BK_DATA;
          end
        end
        default: ;
      endcase
    end
  end

  AST_ACK_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_lvl);                                    // R11
  AST_ACK_RELEASE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe) |-> !scl_lvl);                                    // R11
  AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SKIP) |-> (!sda_oe && !idx_load && !data_load));   // R3
  AST_START_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (kind == BK_ADDR && !sda_oe));                    // R9

endmodule

// File: rtl/ctl_reg_bank.sv
module ctl_reg_bank
  import aud_ctl_pkg::*;
#(
  parameter int         VOL_W     = 8,
  parameter int         TONE_W    = 6,
  parameter int         NUM_REGS  = NUM_CTL_REGS,
  parameter logic [5:0] TONE_FLAT = 6'h1F
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                idx_load,
  input  logic                data_load,
  input  logic [7:0]          wr_byte,
  output logic [VOL_W-1:0]    vol_ch1,
  output logic [VOL_W-1:0]    vol_ch2,
  output logic [TONE_W-1:0]   bass,
  output logic [TONE_W-1:0]   treble,
  output logic                surround_en,
  output logic [NUM_REGS-1:0] wr_strobe
);

  localparam int         IDX_W     = $clog2(NUM_REGS);
  localparam logic [7:0] REG_LIMIT = 8'(NUM_REGS);
  localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(NUM_REGS - 1);

  logic [IDX_W-1:0] cur_idx;
  logic             idx_ok;

  function automatic logic [IDX_W-1:0] ring_next(input logic [IDX_W-1:0] i);
    return (i == IDX_TOP) ? '0 : i + IDX_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_idx     <= '0;
      idx_ok      <= 1'b0;
      vol_ch1     <= '0;
      vol_ch2     <= '0;
      bass        <= TONE_FLAT[TONE_W-1:0];
      treble      <= TONE_FLAT[TONE_W-1:0];
      surround_en <= 1'b0;
      wr_strobe   <= '0;
    end else begin
      wr_strobe <= '0;
      if (idx_load) begin
        idx_ok  <= (wr_byte < REG_LIMIT);
        cur_idx <= wr_byte[IDX_W-1:0];
      end else if (data_load && idx_ok) begin
        wr_strobe <= NUM_REGS'(1) << cur_idx;
        cur_idx   <= ring_next(cur_idx);
        unique case (3'(cur_idx))
          IDX_VOL1: vol_ch1     <= wr_byte[VOL_W-1:0];
          IDX_VOL2: vol_ch2     <= wr_byte[VOL_W-1:0];
          IDX_BASS: bass        <= wr_byte[TONE_W-1:0];
          IDX_TREB: treble      <= wr_byte[TONE_W-1:0];
          default:  surround_en <= wr_byte[0];
        endcase
      end
    end
  end

  AST_IDX_IN_RING: assert property (@(posedge clk) disable iff (!rst_n)
    idx_ok |-> (cur_idx <= IDX_TOP));                           // R5
  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_strobe));                                       // R10
  AST_VOL1_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_strobe[0] |-> $stable(vol_ch1));                        // R10
  AST_BASS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_strobe[2] |-> $stable(bass));                           // R10
  AST_DISCARD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (data_load && !idx_ok) |=> (wr_strobe == '0));              // R8

endmodule

// File: rtl/audio_ctl_i2c_slave.sv
module audio_ctl_i2c_slave
  import aud_ctl_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [5:0] DEV_ADDR_HI = 6'b100000,
  parameter int         VOL_W       = 8,
  parameter int         TONE_W      = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_sel,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [VOL_W-1:0]  vol_ch1,
  output logic [VOL_W-1:0]  vol_ch2,
  output logic [TONE_W-1:0] bass,
  output logic [TONE_W-1:0] treble,
  output logic              surround_en,
  output logic [4:0]        wr_strobe
);

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic idx_load, data_load;
  logic [7:0] rx_byte;

  i2c_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
  );

  i2c_byte_engine #(.DEV_ADDR_HI(DEV_ADDR_HI)) u_engine (
    .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .sda_oe(sda_oe), .idx_load(idx_load), .data_load(data_load),
    .rx_byte(rx_byte)
  );

  ctl_reg_bank #(.VOL_W(VOL_W), .TONE_W(TONE_W), .NUM_REGS(NUM_CTL_REGS)) u_regs (
    .clk(clk), .rst_n(rst_n), .idx_load(idx_load), .data_load(data_load),
    .wr_byte(rx_byte), .vol_ch1(vol_ch1), .vol_ch2(vol_ch2),
    .bass(bass), .treble(treble), .surround_en(surround_en),
    .wr_strobe(wr_strobe)
  );

endmodule

// File: tb/test_audio_ctl_i2c_slave.sv
`timescale 1ns/1ps
module test_audio_ctl_i2c_slave;

  localparam int Q = 500;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic addr_sel = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic       sda_oe;
  logic [7:0] vol_ch1, vol_ch2;
  logic [5:0] bass, treble;
  logic       surround_en;
  logic [4:0] wr_strobe;
  wire        sda_bus = sda_m & ~sda_oe;

  int n_chk = 0;
  int n_bad = 0;
  int strobe_cnt = 0;
  bit finished = 1'b0;
  logic [7:0] pv1;
  logic [7:0] pay [8];
  int pay_n;

  always #10 clk = ~clk;

  audio_ctl_i2c_slave i_audio_ctl_i2c_slave (
    .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe(sda_oe), .vol_ch1(vol_ch1), .vol_ch2(vol_ch2), .bass(bass),
    .treble(treble), .surround_en(surround_en), .wr_strobe(wr_strobe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Strobe monitor (R10): one-hot, and vol_ch1 moves only with its strobe bit.
  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_strobe != 5'd0) strobe_cnt++;
      if ($countones(wr_strobe) > 1) chk("R10 onehot", {27'd0, wr_strobe}, 32'd1);
      if (vol_ch1 !== pv1) chk("R10 vol1 change needs strobe", {31'd0, wr_strobe[0]}, 32'd1);
    end
    pv1 = vol_ch1;
  end

  task automatic bus_start();
    sda_m = 1'b1; #Q; scl_m = 1'b1; #Q; sda_m = 1'b0; #Q; scl_m = 1'b0; #Q;
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; #Q; scl_m = 1'b1; #Q; sda_m = 1'b1; #(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; #Q; scl_m = 1'b1; #(2*Q); scl_m = 1'b0; #Q;
    end
    sda_m = 1'b1; #Q; scl_m = 1'b1; #Q;
    acked = (sda_bus == 1'b0);
    #Q; scl_m = 1'b0; #Q;
    if (acked) chk("R11 ack released after ninth clock", {31'd0, sda_oe}, 32'd0);
  endtask

  task automatic run_xfer(input logic [7:0] a, output int n_ack);
    bit k;
    n_ack = 0;
    bus_start();
    send_byte(a, k); if (k) n_ack++;
    for (int i = 0; i < pay_n; i++) begin
      send_byte(pay[i], k); if (k) n_ack++;
    end
    bus_stop();
  endtask

  task automatic t_reset();
    chk("R1 vol1", {24'd0, vol_ch1}, 32'h00);
    chk("R1 vol2", {24'd0, vol_ch2}, 32'h00);
    chk("R1 bass", {26'd0, bass}, 32'h1F);
    chk("R1 treble", {26'd0, treble}, 32'h1F);
    chk("R1 surround", {31'd0, surround_en}, 32'd0);
    chk("R1 sda_oe", {31'd0, sda_oe}, 32'd0);
    chk("R1 strobe", {27'd0, wr_strobe}, 32'd0);
  endtask

  task automatic t_basic();
    int na;
    addr_sel = 1'b0;
    pay[0] = 8'h00; pay[1] = 8'hA5; pay_n = 2;
    run_xfer(8'h80, na);
    chk("R2 acks strap low", na, 3);
    chk("R4 vol1 written MSB first", {24'd0, vol_ch1}, 32'hA5);
  endtask

  task automatic t_strap();
    int na;
    addr_sel = 1'b1;
    pay[0] = 8'h01; pay[1] = 8'h3C; pay_n = 2;
    run_xfer(8'h80, na);
    chk("R3 wrong address no ack", na, 0);
    chk("R3 wrong address no write", {24'd0, vol_ch2}, 32'h00);
    run_xfer(8'h82, na);
    chk("R2 acks strap high", na, 3);
    chk("R4 vol2 written", {24'd0, vol_ch2}, 32'h3C);
  endtask

  task automatic t_read_bit();
    int na;
    addr_sel = 1'b1;
    pay[0] = 8'h00; pay[1] = 8'h11; pay_n = 2;
    run_xfer(8'h83, na);
    chk("R3 read bit no ack", na, 0);
    chk("R3 read bit no write", {24'd0, vol_ch1}, 32'hA5);
    addr_sel = 1'b0;
  endtask

  task automatic t_wrap();
    int na, s0;
    s0 = strobe_cnt;
    pay[0] = 8'h03; pay[1] = 8'h2A; pay[2] = 8'h01; pay[3] = 8'h11; pay[4] = 8'h22; pay_n = 5;
    run_xfer(8'h80, na);
    chk("R5 acks", na, 6);
    chk("R5 treble", {26'd0, treble}, 32'h2A);
    chk("R5 surround", {31'd0, surround_en}, 32'd1);
    chk("R5 wrap to vol1", {24'd0, vol_ch1}, 32'h11);
    chk("R5 vol2", {24'd0, vol_ch2}, 32'h22);
    chk("R10 strobe count", strobe_cnt - s0, 4);
  endtask

  task automatic t_mask();
    int na;
    pay[0] = 8'h02; pay[1] = 8'hFF; pay[2] = 8'hC7; pay[3] = 8'hFE; pay_n = 4;
    run_xfer(8'h80, na);
    chk("R7 acks", na, 5);
    chk("R7 bass masked", {26'd0, bass}, 32'h3F);
    chk("R7 treble masked", {26'd0, treble}, 32'h07);
    chk("R7 surround bit0 only", {31'd0, surround_en}, 32'd0);
  endtask

  task automatic t_no_second_index();
    int na;
    pay[0] = 8'h00; pay[1] = 8'h55; pay[2] = 8'h02; pay_n = 3;
    run_xfer(8'h80, na);
    chk("R6 vol1", {24'd0, vol_ch1}, 32'h55);
    chk("R6 0x02 stored as data", {24'd0, vol_ch2}, 32'h02);
    chk("R6 bass untouched", {26'd0, bass}, 32'h3F);
  endtask

  task automatic t_bad_index();
    int na, s0;
    s0 = strobe_cnt;
    pay[0] = 8'h07; pay[1] = 8'h99; pay[2] = 8'h77; pay_n = 3;
    run_xfer(8'h80, na);
    chk("R8 acks index 7", na, 4);
    pay[0] = 8'h05; pay[1] = 8'h12; pay_n = 2;
    run_xfer(8'h80, na);
    chk("R8 acks index 5", na, 3);
    chk("R8 no strobe", strobe_cnt - s0, 0);
    chk("R8 vol1 kept", {24'd0, vol_ch1}, 32'h55);
    chk("R8 vol2 kept", {24'd0, vol_ch2}, 32'h02);
  endtask

  task automatic t_restart();
    bit k;
    int na;
    bus_start();
    send_byte(8'h80, k); send_byte(8'h02, k); send_byte(8'h10, k);
    bus_start();
    send_byte(8'h80, k); send_byte(8'h00, k); send_byte(8'h40, k);
    bus_stop();
    chk("R9 before restart", {26'd0, bass}, 32'h10);
    chk("R9 after restart index 0", {24'd0, vol_ch1}, 32'h40);
    na = 0;
    bus_start();
    send_byte(8'h80, k); send_byte(8'h01, k);
    bus_start();
    send_byte(8'h84, k); if (k) na++;
    send_byte(8'h66, k); if (k) na++;
    bus_stop();
    chk("R9 restart to other address no ack", na, 0);
    chk("R9 vol2 unchanged", {24'd0, vol_ch2}, 32'h02);
  endtask

  initial begin
    #(3500000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(4*Q);
    t_reset();
    rst_n = 1'b1;
    #(2*Q);
    t_reset();
    t_basic();
    t_strap();
    t_read_bit();
    t_wrap();
    t_mask();
    t_no_second_index();
    t_bad_index();
    t_restart();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule